// File: doc/BRIEF.md
# Write-Update Snooping Line Controller

This block keeps the coherence state and the data copy of one cache line in a write-update snooping system. The five states are invalid, exclusive clean, shared clean, shared owner (dirty, with at most one such holder in the system) and modified. A write to a line that other caches also hold does not invalidate them. The controller broadcasts the new word on the bus instead, and the last writer becomes the owner of the dirty copy.

On the processor side the controller takes read, write and evict commands, one at a time. It issues bus Read, Update and Write-back transactions, and it samples the bus "shared" wire in the grant cycle to choose its next state. A write miss that finds sharers performs a Read followed by an Update, and both are marked locked so that the arbiter keeps the pair atomic. On the snoop side the controller watches other masters' Read and Update transactions. It reports that it holds a copy, supplies the line and inhibits memory when it owns dirty data, and merges broadcast words into its own copy. Arbitration, the data array around the line and the memory are outside the block.

Top module: `dwu_line_ctrl`

## Requirements
- R1: After reset the line state is invalid (code 0), no bus request is raised and the processor port is ready. The state codes are 0 invalid, 1 exclusive clean, 2 shared clean, 3 shared owner and 4 modified, and no other code appears.
- R2: A read command in state 0 raises a bus Read (command code 1). In the grant cycle the state becomes 1 if shared is low and 2 if shared is high. The read data is the granted fill line's word at the requested offset, and the fill line becomes the stored line.
- R3: A write command in state 0 raises a locked bus Read. With shared low in that grant the word is merged into the fill line and the state becomes 4. With shared high the controller next raises a locked Update (code 2) and ends in state 3.
- R4: A write command in state 2 or 3 raises an Update that carries the word offset, byte enables and data. The state becomes 4 if shared is low in the grant cycle and 3 otherwise.
- R5: A write command in state 1 or 4 merges the word under its byte enables, ends in state 4 and raises no bus request.
- R6: A snooped Read (code 1) in state 1 drives shared and moves to state 2. In state 3 or 4 it drives shared, supply and memory-inhibit and ends in state 3. In state 2 it drives only shared. In state 0 it has no effect.
- R7: A snooped Update (code 2) in state 2 or 3 drives shared, merges the broadcast word into the stored line under its byte enables, and ends in state 2. In states 0, 1 and 4 it changes neither the state nor the stored line and drives nothing.
- R8: An evict command in state 3 or 4 raises a Write-back (code 3) while the stored line is presented, and the state becomes 0 on grant. An evict in state 1 or 2 moves to state 0 with no bus request.
- R9: When a snoop arrives while a processor command is pending, the snoop takes effect first. The command is then carried out from the state the snoop left. For example, a write pending in state 1 that meets a snooped Read becomes an Update from state 2.
- R10: A read command in any state other than 0 returns the stored word at the requested offset one cycle after acceptance and raises no bus request.
- R11: At most one command is outstanding. Ready is low from acceptance until the done pulse, and no bus request is raised while ready is high.
- R12: Processor command codes are 1 read, 2 write and 3 evict. Done pulses for one cycle, in the cycle after the command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor command valid |
| cpu_req_op | input | 2 | 1 read, 2 write, 3 evict |
| cpu_req_word | input | IDX_W | Word offset in the line |
| cpu_req_be | input | BE_W | Byte enables for a write |
| cpu_req_data | input | DATA_W | Write word |
| cpu_ready | output | 1 | Command accepted when high |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with done |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 1 Read, 2 Update, 3 Write-back |
| bus_req_lock | output | 1 | Keep this and the next transaction atomic |
| bus_req_word | output | IDX_W | Update word offset |
| bus_req_be | output | BE_W | Update byte enables |
| bus_req_data | output | DATA_W | Update word |
| bus_gnt | input | 1 | Requested transaction performed this cycle |
| bus_shared_in | input | 1 | Shared wire sampled with grant |
| bus_fill_line | input | LINE_W | Line returned by a granted Read |
| snp_valid | input | 1 | Another master's transaction is snooped |
| snp_cmd | input | 2 | 1 Read, 2 Update |
| snp_word | input | IDX_W | Snooped update offset |
| snp_be | input | BE_W | Snooped update byte enables |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared_out | output | 1 | This cache holds a copy |
| snp_supply | output | 1 | line_data carries the line for the snooped Read |
| mem_inhibit | output | 1 | Memory must not drive data |
| line_data | output | LINE_W | Stored line copy |
| line_state | output | 3 | Current coherence state code |

## Verification
The two functions that can meet in one cycle are the snoop response and a pending processor command that would finish without the bus, such as a write in the exclusive state. The bench presents a snooped Read in the first cycle after such a write is accepted. It then expects the shared response in that cycle and, after it, an Update from the shared clean state. The state that results and the merged word show whether the snoop was ordered first. Random mixes of snoops and commands also place snoops between a request and its grant.

// File: rtl/dwu_pkg.sv
// Shared types for the write-update line controller.
// Assumes a single cache line per controller instance.
package dwu_pkg;

    typedef enum logic [2:0] {
        LS_I  = 3'd0,
        LS_E  = 3'd1,
        LS_SC = 3'd2,
        LS_SM = 3'd3,
        LS_M  = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_READ   = 2'd1,
        BC_UPDATE = 2'd2,
        BC_WRBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PO_NONE  = 2'd0,
        PO_READ  = 2'd1,
        PO_WRITE = 2'd2,
        PO_EVICT = 2'd3
    } cpu_op_e;

    // True when the copy is dirty and this cache answers for it.
    function automatic logic is_owner(line_state_e s);
        return (s == LS_SM) || (s == LS_M);
    endfunction

    // True when other caches may hold the line too.
    function automatic logic is_shared_copy(line_state_e s);
        return (s == LS_SC) || (s == LS_SM);
    endfunction

endpackage

// File: rtl/dwu_line_store.sv
// Holds the data copy of the line. A fill replaces the whole line, and a
// local write or a snooped update merges one word under byte enables.
// Assumes that the local write and the snooped merge never fall in the
// same cycle. A local write in a fill cycle lands on top of the fill.
module dwu_line_store #(
    parameter  int DATA_W = 32,
    parameter  int WORDS  = 4,
    localparam int BE_W   = DATA_W / 8,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mrg_en,
    input  logic [IDX_W-1:0]  mrg_idx,
    input  logic [BE_W-1:0]   mrg_be,
    input  logic [DATA_W-1:0] mrg_data,
    output logic [LINE_W-1:0] line_q
);

    logic [LINE_W-1:0] base;
    logic [LINE_W-1:0] nxt;

    // Choose the starting point for this cycle's merge.
    always_comb base = fill_en ? fill_line : line_q;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BE_W; b++) begin : g_byte
            localparam int POS = w * DATA_W + b * 8;
            // Pick each byte from the local write, the snoop or the base.
            always_comb begin
                if (wr_en && wr_idx == IDX_W'(w) && wr_be[b])
                    nxt[POS +: 8] = wr_data[b*8 +: 8];
                else if (mrg_en && mrg_idx == IDX_W'(w) && mrg_be[b])
                    nxt[POS +: 8] = mrg_data[b*8 +: 8];
                else
                    nxt[POS +: 8] = base[POS +: 8];
            end
        end
    end

    // Line register.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= nxt;
    end

endmodule

// File: rtl/dwu_snoop_resp.sv
// Decodes the response to another master's Read or Update from the
// current line state. Purely combinational; the snoop outcome is applied
// in the same cycle and overrides any processor-side state change.
module dwu_snoop_resp
    import dwu_pkg::*;
(
    input  logic        snp_valid,
    input  logic [1:0]  snp_cmd,
    input  line_state_e state_i,
    output logic        shared_o,
    output logic        supply_o,
    output logic        mrg_en_o,
    output logic        st_we_o,
    output line_state_e st_nxt_o
);

    // Snoop response and next state per current state.
    always_comb begin
        shared_o = 1'b0;
        supply_o = 1'b0;
        mrg_en_o = 1'b0;
        st_we_o  = 1'b0;
        st_nxt_o = state_i;
        if (snp_valid) begin
            if (snp_cmd == BC_READ) begin
                if (state_i == LS_E) begin
                    shared_o = 1'b1;
                    st_we_o  = 1'b1;
                    st_nxt_o = LS_SC;
                end else if (state_i == LS_SC) begin
                    shared_o = 1'b1;
                end else if (is_owner(state_i)) begin
                    shared_o = 1'b1;
                    supply_o = 1'b1;
                    st_we_o  = 1'b1;
                    st_nxt_o = LS_SM;
                end
            end else if (snp_cmd == BC_UPDATE && is_shared_copy(state_i)) begin
                shared_o = 1'b1;
                mrg_en_o = 1'b1;
                st_we_o  = 1'b1;
                st_nxt_o = LS_SC;
            end
        end
    end

endmodule

// File: rtl/dwu_proc_seq.sv
// Processor-side sequencer. Latches one command, then each cycle derives
// the needed bus action from the current state, so a snoop that changes
// the state while the command waits alters what is done. Completion is
// held off in any cycle with a snoop. Assumes bus_gnt only follows a
// raised request and never coincides with snp_valid.
module dwu_proc_seq
    import dwu_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int WORDS  = 4,
    localparam int BE_W   = DATA_W / 8,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_data,
    output logic              ready,
    input  line_state_e       state_i,
    input  logic              snp_valid,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] cur_word,
    input  logic [DATA_W-1:0] fill_word,
    output logic [IDX_W-1:0]  p_idx,
    output logic [BE_W-1:0]   p_be,
    output logic [DATA_W-1:0] p_data,
    output logic              bus_valid,
    output bus_cmd_e          bus_cmd,
    output logic              bus_lock,
    output logic              fill_en,
    output logic              wr_en,
    output logic              st_we,
    output line_state_e       st_nxt,
    output logic              done_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic    busy;
    logic    phase2;
    cpu_op_e p_op;
    logic    go;
    logic    fin;
    logic    enter2;

    assign ready = !busy;
    assign go    = bus_gnt && !snp_valid;

    // Action for the pending command in the current state.
    always_comb begin
        bus_valid = 1'b0;
        bus_cmd   = BC_NONE;
        bus_lock  = 1'b0;
        fill_en   = 1'b0;
        wr_en     = 1'b0;
        st_we     = 1'b0;
        st_nxt    = state_i;
        fin       = 1'b0;
        enter2    = 1'b0;
        if (busy) begin
            case (p_op)
                PO_READ: begin
                    if (state_i == LS_I) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_READ;
                        if (go) begin
                            fill_en = 1'b1;
                            st_we   = 1'b1;
                            st_nxt  = bus_shared ? LS_SC : LS_E;
                            fin     = 1'b1;
                        end
                    end else if (!snp_valid) begin
                        fin = 1'b1;
                    end
                end
                PO_WRITE: begin
                    if (phase2) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_UPDATE;
                        bus_lock  = 1'b1;
                        if (go) begin
                            wr_en  = 1'b1;
                            st_we  = 1'b1;
                            st_nxt = LS_SM;
                            fin    = 1'b1;
                        end
                    end else if (state_i == LS_I) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_READ;
                        bus_lock  = 1'b1;
                        if (go) begin
                            fill_en = 1'b1;
                            st_we   = 1'b1;
                            if (bus_shared) begin
                                st_nxt = LS_SC;
                                enter2 = 1'b1;
                            end else begin
                                wr_en  = 1'b1;
                                st_nxt = LS_M;
                                fin    = 1'b1;
                            end
                        end
                    end else if (is_shared_copy(state_i)) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_UPDATE;
                        if (go) begin
                            wr_en  = 1'b1;
                            st_we  = 1'b1;
                            st_nxt = bus_shared ? LS_SM : LS_M;
                            fin    = 1'b1;
                        end
                    end else if (!snp_valid) begin
                        wr_en  = 1'b1;
                        st_we  = 1'b1;
                        st_nxt = LS_M;
                        fin    = 1'b1;
                    end
                end
                PO_EVICT: begin
                    if (is_owner(state_i)) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_WRBACK;
                        if (go) begin
                            st_we  = 1'b1;
                            st_nxt = LS_I;
                            fin    = 1'b1;
                        end
                    end else if (!snp_valid) begin
                        st_we  = 1'b1;
                        st_nxt = LS_I;
                        fin    = 1'b1;
                    end
                end
                default: fin = 1'b1;
            endcase
        end
    end

    // Command latch, phase tracking and completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            phase2  <= 1'b0;
            p_op    <= PO_NONE;
            p_idx   <= '0;
            p_be    <= '0;
            p_data  <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= fin;
            if (fin) begin
                busy    <= 1'b0;
                phase2  <= 1'b0;
                rdata_q <= (p_op == PO_READ) ? (fill_en ? fill_word : cur_word) : '0;
            end else if (enter2) begin
                phase2 <= 1'b1;
            end
            if (!busy && req_valid && req_op != PO_NONE) begin
                busy   <= 1'b1;
                p_op   <= cpu_op_e'(req_op);
                p_idx  <= req_idx;
                p_be   <= req_be;
                p_data <= req_data;
            end
        end
    end

endmodule

// File: rtl/dwu_line_ctrl.sv
// Per-line controller for a write-update snooping protocol. Combines the
// processor sequencer, the snoop decoder and the line store around one
// state register; a snoop's state change wins over the sequencer's.
// Assumes the arbiter never grants this cache in a snoop cycle and keeps
// other masters off the bus while bus_req_lock is high.
module dwu_line_ctrl
    import dwu_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int WORDS  = 4,
    localparam int BE_W   = DATA_W / 8,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic [1:0]        cpu_req_op,
    input  logic [IDX_W-1:0]  cpu_req_word,
    input  logic [BE_W-1:0]   cpu_req_be,
    input  logic [DATA_W-1:0] cpu_req_data,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic              bus_req_lock,
    output logic [IDX_W-1:0]  bus_req_word,
    output logic [BE_W-1:0]   bus_req_be,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic [LINE_W-1:0] bus_fill_line,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [IDX_W-1:0]  snp_word,
    input  logic [BE_W-1:0]   snp_be,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_shared_out,
    output logic              snp_supply,
    output logic              mem_inhibit,
    output logic [LINE_W-1:0] line_data,
    output logic [2:0]        line_state
);

    line_state_e st_q;
    line_state_e s_nxt;
    line_state_e p_nxt;
    bus_cmd_e    p_cmd;
    logic        s_we;
    logic        p_we;
    logic        s_mrg;
    logic        p_fill;
    logic        p_wr;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] fill_word;

    dwu_proc_seq #(.DATA_W(DATA_W), .WORDS(WORDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (cpu_req_valid),
        .req_op    (cpu_req_op),
        .req_idx   (cpu_req_word),
        .req_be    (cpu_req_be),
        .req_data  (cpu_req_data),
        .ready     (cpu_ready),
        .state_i   (st_q),
        .snp_valid (snp_valid),
        .bus_gnt   (bus_gnt),
        .bus_shared(bus_shared_in),
        .cur_word  (cur_word),
        .fill_word (fill_word),
        .p_idx     (bus_req_word),
        .p_be      (bus_req_be),
        .p_data    (bus_req_data),
        .bus_valid (bus_req_valid),
        .bus_cmd   (p_cmd),
        .bus_lock  (bus_req_lock),
        .fill_en   (p_fill),
        .wr_en     (p_wr),
        .st_we     (p_we),
        .st_nxt    (p_nxt),
        .done_q    (cpu_done),
        .rdata_q   (cpu_rdata)
    );

    dwu_snoop_resp u_snp (
        .snp_valid(snp_valid),
        .snp_cmd  (snp_cmd),
        .state_i  (st_q),
        .shared_o (snp_shared_out),
        .supply_o (snp_supply),
        .mrg_en_o (s_mrg),
        .st_we_o  (s_we),
        .st_nxt_o (s_nxt)
    );

    dwu_line_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (p_fill),
        .fill_line(bus_fill_line),
        .wr_en    (p_wr),
        .wr_idx   (bus_req_word),
        .wr_be    (bus_req_be),
        .wr_data  (bus_req_data),
        .mrg_en   (s_mrg),
        .mrg_idx  (snp_word),
        .mrg_be   (snp_be),
        .mrg_data (snp_data),
        .line_q   (line_data)
    );

    // Word selection for read return.
    always_comb begin
        cur_word  = line_data[int'(bus_req_word) * DATA_W +: DATA_W];
        fill_word = bus_fill_line[int'(bus_req_word) * DATA_W +: DATA_W];
    end

    assign bus_req_cmd = p_cmd;
    assign mem_inhibit = snp_supply;
    assign line_state  = st_q;

    // Coherence state register, snoop first.
    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= LS_I;
        else if (s_we) st_q <= s_nxt;
        else if (p_we) st_q <= p_nxt;
    end

endmodule

// File: rtl/dwu_line_ctrl_chk.sv
// Protocol checker for the line controller, bound into every instance.
module dwu_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] line_state,
    input logic       bus_req_valid,
    input logic [1:0] bus_req_cmd,
    input logic       cpu_ready,
    input logic       mem_inhibit,
    input logic       snp_valid,
    input logic [1:0] snp_cmd
);

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        line_state <= 3'd4); // R1

    AST_INHIBIT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> (line_state == 3'd3 || line_state == 3'd4)); // R6

    AST_SNPRD_E_TO_SC: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd1 && line_state == 3'd1) |=> line_state == 3'd2); // R6

    AST_SNPUPD_TO_SC: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd2 && (line_state == 3'd2 || line_state == 3'd3))
        |=> line_state == 3'd2); // R7

    AST_E_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd1) |-> !bus_req_valid); // R5

    AST_WB_DIRTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == 2'd3) |-> (line_state == 3'd3 || line_state == 3'd4)); // R8

    AST_NO_REQ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !cpu_ready); // R11

endmodule

bind dwu_line_ctrl dwu_line_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_state   (line_state),
    .bus_req_valid(bus_req_valid),
    .bus_req_cmd  (bus_req_cmd),
    .cpu_ready    (cpu_ready),
    .mem_inhibit  (mem_inhibit),
    .snp_valid    (snp_valid),
    .snp_cmd      (snp_cmd)
);

// File: tb/sim_dwu_line_ctrl.sv
`timescale 1ns/1ps
module sim_dwu_line_ctrl;

    localparam int DW = 32;
    localparam int NW = 4;
    localparam int BW = DW / 8;
    localparam int IW = 2;
    localparam int LW = DW * NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic [1:0]    cpu_req_op = '0;
    logic [IW-1:0] cpu_req_word = '0;
    logic [BW-1:0] cpu_req_be = '0;
    logic [DW-1:0] cpu_req_data = '0;
    logic          cpu_ready, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req_valid, bus_req_lock;
    logic [1:0]    bus_req_cmd;
    logic [IW-1:0] bus_req_word;
    logic [BW-1:0] bus_req_be;
    logic [DW-1:0] bus_req_data;
    logic          bus_gnt = 1'b0, bus_shared_in = 1'b0;
    logic [LW-1:0] bus_fill_line = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [IW-1:0] snp_word = '0;
    logic [BW-1:0] snp_be = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_shared_out, snp_supply, mem_inhibit;
    logic [LW-1:0] line_data;
    logic [2:0]    line_state;

    int nchk = 0;
    int nfail = 0;
    logic [2:0]    m_st = 3'd0;
    logic [LW-1:0] m_line = '0;

    always #2.5 clk = ~clk;

    dwu_line_ctrl #(.DATA_W(DW), .WORDS(NW)) u0 (.*);

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] merge(input logic [LW-1:0] l, input int w,
                                            input logic [BW-1:0] be, input logic [DW-1:0] d);
        logic [LW-1:0] r = l;
        for (int b = 0; b < BW; b++)
            if (be[b]) r[w*DW + b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    // Processor command with expected bus sequence from the model.
    task automatic cpu(input logic [1:0] op, input int w, input logic [BW-1:0] be,
                       input logic [DW-1:0] d, input bit sh1, input string rq);
        logic [LW-1:0] fill = {$urandom, $urandom, $urandom, $urandom};
        logic [1:0] e1 = 2'd0, e2 = 2'd0, a1 = 2'd0, a2 = 2'd0;
        logic [2:0] est = m_st;
        logic [LW-1:0] eline = m_line;
        logic [DW-1:0] erd = '0, ard = '0;
        bit got = 0, lk1 = 0;
        int n = 0;
        case (op)
            2'd1: if (m_st == 3'd0) begin
                    e1 = 2'd1; est = sh1 ? 3'd2 : 3'd1; eline = fill; erd = fill[w*DW +: DW];
                  end else erd = m_line[w*DW +: DW];
            2'd2: if (m_st == 3'd0) begin
                    e1 = 2'd1; eline = merge(fill, w, be, d);
                    if (sh1) begin e2 = 2'd2; est = 3'd3; end else est = 3'd4;
                  end else if (m_st == 3'd2 || m_st == 3'd3) begin
                    e1 = 2'd2; est = sh1 ? 3'd3 : 3'd4; eline = merge(m_line, w, be, d);
                  end else begin
                    est = 3'd4; eline = merge(m_line, w, be, d);
                  end
            default: begin
                    if (m_st == 3'd3 || m_st == 3'd4) e1 = 2'd3;
                    est = 3'd0;
                  end
        endcase
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_word = IW'(w);
        cpu_req_be = be; cpu_req_data = d; bus_fill_line = fill;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        check(cpu_ready == 1'b0, "R11", "ready while pending", LW'(cpu_ready), '0);
        for (int k = 0; k < 8 && !got; k++) begin
            if (cpu_done) begin
                got = 1; ard = cpu_rdata;
            end else begin
                if (bus_req_valid) begin
                    n++;
                    if (n == 1) begin a1 = bus_req_cmd; lk1 = bus_req_lock; end
                    else a2 = bus_req_cmd;
                    if (bus_req_cmd == 2'd2)
                        check(bus_req_word == IW'(w) && bus_req_be == be && bus_req_data == d,
                              (m_st == 3'd0) ? "R3" : "R4", "update payload",
                              LW'({bus_req_word, bus_req_be, bus_req_data}), LW'({IW'(w), be, d}));
                    if (bus_req_cmd == 2'd3)
                        check(line_data == m_line, "R8", "write-back line", line_data, m_line);
                    bus_gnt = 1'b1;
                    bus_shared_in = (n == 1) ? sh1 : 1'b1;
                end
                @(negedge clk);
                bus_gnt = 1'b0; bus_shared_in = 1'b0;
            end
        end
        check(got, "R12", "done pulse", LW'(got), LW'(1));
        check(a1 == e1 && a2 == e2, rq, "bus commands", LW'({a1, a2}), LW'({e1, e2}));
        if (op == 2'd2 && m_st == 3'd0)
            check(lk1 == 1'b1, "R3", "locked read", LW'(lk1), LW'(1));
        if (op == 2'd1)
            check(ard == erd, (m_st == 3'd0) ? "R2" : "R10", "read data", LW'(ard), LW'(erd));
        check(line_state == est, rq, "state", LW'(line_state), LW'(est));
        check(line_data == eline, rq, "line", line_data, eline);
        m_st = est; m_line = eline;
    endtask

    // Snoop one transaction and compare the response.
    task automatic snoop(input logic [1:0] c, input int w, input logic [BW-1:0] be,
                         input logic [DW-1:0] d, input string rq);
        bit esh = 0, esup = 0;
        logic [2:0] est = m_st;
        logic [LW-1:0] eline = m_line;
        if (c == 2'd1) begin
            esh = (m_st != 3'd0);
            esup = (m_st == 3'd3 || m_st == 3'd4);
            if (m_st == 3'd1) est = 3'd2;
            if (esup) est = 3'd3;
        end else if (m_st == 3'd2 || m_st == 3'd3) begin
            esh = 1; est = 3'd2; eline = merge(m_line, w, be, d);
        end
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_word = IW'(w); snp_be = be; snp_data = d;
        #1;
        check(snp_shared_out == esh && snp_supply == esup && mem_inhibit == esup, rq,
              "snoop response", LW'({snp_shared_out, snp_supply, mem_inhibit}), LW'({esh, esup, esup}));
        @(negedge clk);
        snp_valid = 1'b0;
        check(line_state == est, rq, "snoop state", LW'(line_state), LW'(est));
        check(line_data == eline, rq, "snoop line", line_data, eline);
        m_st = est; m_line = eline;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_state == 3'd0 && !bus_req_valid && cpu_ready, "R1", "reset state",
              LW'({line_state, bus_req_valid, cpu_ready}), LW'({3'd0, 1'b0, 1'b1}));

        cpu(2'd1, 1, '1, 0, 0, "R2");                    // miss, alone -> E
        cpu(2'd2, 1, 4'b0101, 32'hA1B2C3D4, 0, "R5");    // E write, silent
        snoop(2'd1, 0, '0, 0, "R6");                     // M supplies -> Sm
        cpu(2'd2, 2, '1, 32'h12345678, 0, "R4");         // Sm update alone -> M
        cpu(2'd3, 0, '0, 0, 0, "R8");                    // M write-back
        cpu(2'd1, 3, '1, 0, 1, "R2");                    // miss shared -> Sc
        snoop(2'd2, 3, 4'b1100, 32'hDEADBEEF, "R7");     // merge in Sc
        cpu(2'd2, 0, '1, 32'hCAFEF00D, 1, "R4");         // Sc update shared -> Sm
        snoop(2'd1, 1, '0, 0, "R6");                     // Sm supplies
        snoop(2'd2, 2, 4'b0011, 32'h0BAD0BAD, "R7");     // Sm -> Sc
        cpu(2'd1, 3, '0, 0, 0, "R10");                   // read hit
        cpu(2'd3, 0, '0, 0, 0, "R8");                    // Sc evict silent
        snoop(2'd2, 0, '1, 32'h11111111, "R7");          // ignored in I
        cpu(2'd2, 1, '1, 32'h55AA55AA, 0, "R3");         // write miss alone -> M
        snoop(2'd2, 1, '1, 32'h22222222, "R7");          // ignored in M
        cpu(2'd3, 0, '0, 0, 0, "R8");
        cpu(2'd2, 2, 4'b1001, 32'h87654321, 1, "R3");    // write miss shared -> Sm
        cpu(2'd3, 0, '0, 0, 0, "R8");

        // R9: snoop Read in the first cycle of a pending write in E.
        cpu(2'd1, 0, '0, 0, 0, "R2");
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_op = 2'd2; cpu_req_word = 2'd1;
        cpu_req_be = '1; cpu_req_data = 32'h9ABCDEF0;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        snp_valid = 1'b1; snp_cmd = 2'd1;
        #1;
        check(snp_shared_out && !bus_req_valid, "R9", "snoop first",
              LW'({snp_shared_out, bus_req_valid}), LW'(2'b10));
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        check(bus_req_valid && bus_req_cmd == 2'd2 && line_state == 3'd2, "R9", "update after snoop",
              LW'({bus_req_valid, bus_req_cmd, line_state}), LW'({1'b1, 2'd2, 3'd2}));
        bus_gnt = 1'b1; bus_shared_in = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0; bus_shared_in = 1'b0;
        m_st = 3'd3; m_line = merge(m_line, 1, '1, 32'h9ABCDEF0);
        check(cpu_done && line_state == 3'd3, "R9", "done in Sm",
              LW'({cpu_done, line_state}), LW'({1'b1, 3'd3}));
        check(line_data == m_line, "R9", "merged word", line_data, m_line);

        // Random mix of commands and snoops.
        for (int i = 0; i < 400; i++) begin
            int w = int'($urandom_range(NW - 1));
            logic [BW-1:0] be = BW'($urandom);
            logic [DW-1:0] d = $urandom;
            if ($urandom_range(9) < 3)
                snoop(2'($urandom_range(2, 1)), w, be, d, "R6_R7");
            else begin
                logic [1:0] op = 2'($urandom_range(3, 1));
                cpu(op, w, be, d, bit'($urandom_range(1)),
                    (op == 2'd1) ? "R2" : (op == 2'd2) ? "R4" : "R8");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule